// File: doc/BRIEF.md
# Per-pin GPIO controller with interrupts

This block drives and samples a vector of general-purpose pins. Software configures each pin through a 32-bit control word of its own. The word holds the following:

- the output value and the direction;
- an interrupt enable and a three-bit trigger code that selects falling edge, rising edge, both edges, level low or level high;
- a detection mask;
- a reset-tolerance flag and two debounce select bits, which are stored but have no effect here;
- a sticky interrupt status bit;
- the live, synchronised input level.

A second kind of word collects the status bits of 32 pins, so one read shows every pending pin of that group. All pending and enabled pins are ORed onto one interrupt line.

The register bus is word-addressed, with a select, a write strobe, an address and write data. Read data comes back combinationally in the same cycle. Pin inputs pass through a two-flop synchroniser. Edges are found by comparing the synchronised level with the sample taken one clock earlier. Software acknowledges a pin by writing 1 to its status bit.

Top module: `gpio_pin_ctrl`

## Requirements
- R1: The control word of pin n is at word address 0x60+n (byte offset 0x180+4n). The status word of group g (pins 32g to 32g+31) is at word address 0x40+g (byte offset 0x100+4g). Any other address reads 0, and writes to it change nothing.
- R2: Control word bits 0 to 9 are writable and read back as written: bit0 output value, bit1 direction (1 = drive), bit2 interrupt enable, bits 3/4/5 trigger code t0/t1/t2, bit6 reset tolerance, bit7 and bit8 debounce selects, bit9 detection mask. Bits 10, 11 and 14 to 31 read 0.
- R3: Bit13 of a control word reads the pin level after the two-flop synchroniser, so a change on the pin is visible after the second rising clock edge. Writes to bit13 are ignored.
- R4: pin_out[n] equals bit0 of pin n's word, and pin_oe[n] equals bit1.
- R5: Reset clears every control field and every status bit. After reset every pin is an input, pin_out and pin_oe are 0, and irq is 0.
- R6: Trigger code {t2,t1,t0}: 000 falling edge, 001 rising edge, 101 both edges, 010 level low, 011 level high. Codes 100, 110 and 111 detect nothing. For an edge, the status bit (bit12) is set on the third rising clock edge after the pin changes.
- R7: A level trigger whose level is still present sets the status bit again on the clock edge after the clear.
- R8: Writing 1 to bit12 clears the status. A write with bit12 = 0 leaves it unchanged. If a clear and a new detection fall in the same cycle, the clear wins.
- R9: Bit k of group g's status word mirrors the status of pin 32g+k. Bits for pins that do not exist read 0. Writes to a group status word are ignored.
- R10: irq is 1 exactly when some pin has both status and enable set. A pin with enable 0 still records status.
- R11: While a pin's mask bit is set, its status is never set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| pin_in | input | NUM_PINS | Raw pin levels |
| pin_out | output | NUM_PINS | Output values |
| pin_oe | output | NUM_PINS | Output enables |
| irq | output | 1 | Combined interrupt |

## Verification
The properties assume the following about the block's inputs:

- write data is valid in the same cycle as the write strobe;
- at most one control word is addressed per cycle;
- reset falls asynchronously before the first clock edge that is checked.

The stimulus meets these assumptions. It changes the bus and the pins only on the falling clock edge and holds each access for exactly one cycle. Between pin changes it leaves at least three clock edges, so that every edge passes fully through the synchroniser and the previous-sample register before the result is sampled.

// File: rtl/gpc_pkg.sv
package gpc_pkg;
    localparam int WORD_W         = 32;
    localparam int CFG_W          = 10;
    localparam int CTRL_WORD_BASE = 'h180 / 4;
    localparam int STAT_WORD_BASE = 'h100 / 4;
    localparam int B_STS          = 12;
    localparam int B_IN           = 13;

    typedef enum logic [2:0] {
        TRIG_FALL   = 3'b000,
        TRIG_RISE   = 3'b001,
        TRIG_LVL_LO = 3'b010,
        TRIG_LVL_HI = 3'b011,
        TRIG_BOTH   = 3'b101
    } trig_e;

    // Packed so that it lines up with control word bits 9..0
    typedef struct packed {
        logic       mask;
        logic       dbs2;
        logic       dbs1;
        logic       tol;
        logic [2:0] trig;
        logic       ien;
        logic       dir;
        logic       dout;
    } pin_cfg_t;
endpackage

// File: rtl/gpc_sync.sv
module gpc_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_o = st_q.s2;
endmodule

// File: rtl/gpc_pin.sv
module gpc_pin
    import gpc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [CFG_W-1:0]  cfg_wr_i,
    input  logic              clr_i,
    input  logic              lvl_i,
    output logic              dout_o,
    output logic              dir_o,
    output logic              ien_o,
    output logic              msk_o,
    output logic              sts_o,
    output logic [WORD_W-1:0] word_o
);
    typedef struct packed {
        pin_cfg_t cfg;
        logic     sts;
        logic     prev;
    } pin_st_t;

    pin_st_t st_d, st_q;
    logic    hit;

    always_comb begin
        case (st_q.cfg.trig)
            TRIG_FALL:   hit = st_q.prev & ~lvl_i;
            TRIG_RISE:   hit = ~st_q.prev & lvl_i;
            TRIG_BOTH:   hit = st_q.prev ^ lvl_i;
            TRIG_LVL_LO: hit = ~lvl_i;
            TRIG_LVL_HI: hit = lvl_i;
            default:     hit = 1'b0;
        endcase

        st_d      = st_q;
        st_d.prev = lvl_i;
        if (wr_en_i) st_d.cfg = pin_cfg_t'(cfg_wr_i);
        // acknowledge takes priority over a detection in the same cycle
        if (wr_en_i && clr_i)              st_d.sts = 1'b0;
        else if (hit && !st_q.cfg.mask)    st_d.sts = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        word_o              = '0;
        word_o[CFG_W-1:0]   = st_q.cfg;
        word_o[B_STS]       = st_q.sts;
        word_o[B_IN]        = lvl_i;
    end

    assign dout_o = st_q.cfg.dout;
    assign dir_o  = st_q.cfg.dir;
    assign ien_o  = st_q.cfg.ien;
    assign msk_o  = st_q.cfg.mask;
    assign sts_o  = st_q.sts;
endmodule

// File: rtl/gpc_rdmux.sv
module gpc_rdmux
    import gpc_pkg::*;
#(
    parameter int NUM_PINS = 40,
    parameter int ADDR_W   = 8
) (
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [WORD_W-1:0]   words_i [NUM_PINS],
    input  logic [NUM_PINS-1:0] sts_i,
    output logic [WORD_W-1:0]   rdata_o
);
    localparam int NUM_BANKS = (NUM_PINS + 31) / 32;

    logic [NUM_BANKS*32-1:0] sts_pad;

    always_comb begin
        sts_pad                = '0;
        sts_pad[NUM_PINS-1:0]  = sts_i;
        rdata_o                = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (addr_i == ADDR_W'(CTRL_WORD_BASE + p)) rdata_o = words_i[p];
        end
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (addr_i == ADDR_W'(STAT_WORD_BASE + b)) rdata_o = sts_pad[b*32 +: 32];
        end
    end
endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
    import gpc_pkg::*;
#(
    parameter int NUM_PINS = 40,
    parameter int ADDR_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [WORD_W-1:0]   bus_wdata,
    output logic [WORD_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                irq
);
    logic [NUM_PINS-1:0] lvl;
    logic [NUM_PINS-1:0] wr_ctrl;
    logic [NUM_PINS-1:0] sts_vec;
    logic [NUM_PINS-1:0] ien_vec;
    logic [NUM_PINS-1:0] msk_vec;
    logic [WORD_W-1:0]   words [NUM_PINS];

    gpc_sync #(.W(NUM_PINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_in),
        .q_o   (lvl)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        assign wr_ctrl[i] = bus_sel && bus_wr && (bus_addr == ADDR_W'(CTRL_WORD_BASE + i));

        gpc_pin u_pin (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en_i  (wr_ctrl[i]),
            .cfg_wr_i (bus_wdata[CFG_W-1:0]),
            .clr_i    (bus_wdata[B_STS]),
            .lvl_i    (lvl[i]),
            .dout_o   (pin_out[i]),
            .dir_o    (pin_oe[i]),
            .ien_o    (ien_vec[i]),
            .msk_o    (msk_vec[i]),
            .sts_o    (sts_vec[i]),
            .word_o   (words[i])
        );
    end

    gpc_rdmux #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_rdmux (
        .addr_i  (bus_addr),
        .words_i (words),
        .sts_i   (sts_vec),
        .rdata_o (bus_rdata)
    );

    assign irq = |(sts_vec & ien_vec);
endmodule

// File: rtl/gpc_checker.sv
module gpc_checker #(
    parameter int NUM_PINS = 40
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wd_dout,
    input logic                wd_dir,
    input logic                wd_clr,
    input logic [NUM_PINS-1:0] wr_ctrl,
    input logic [NUM_PINS-1:0] sts_vec,
    input logic [NUM_PINS-1:0] msk_vec,
    input logic [NUM_PINS-1:0] pin_out,
    input logic [NUM_PINS-1:0] pin_oe,
    input logic                irq
);
    // R5: while reset is held, nothing drives and no interrupt is raised
    always @(negedge clk) begin
        if (!rst_n) begin
            p_reset_quiet_r5: assert (pin_oe == '0 && pin_out == '0 && irq == 1'b0);
        end
    end

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
        p_oe_follows_dir_r4: assert property (@(posedge clk) disable iff (!rst_n)
            wr_ctrl[i] |=> pin_oe[i] == $past(wd_dir));

        p_out_follows_val_r4: assert property (@(posedge clk) disable iff (!rst_n)
            wr_ctrl[i] |=> pin_out[i] == $past(wd_dout));

        p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_ctrl[i] && wd_clr) |=> !sts_vec[i]);

        p_sts_falls_only_on_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(sts_vec[i]) |-> $past(wr_ctrl[i] && wd_clr));

        p_mask_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(sts_vec[i]) |-> !$past(msk_vec[i]));
    end
endmodule

bind gpio_pin_ctrl gpc_checker #(.NUM_PINS(NUM_PINS)) u_gpc_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .wd_dout (bus_wdata[0]),
    .wd_dir  (bus_wdata[1]),
    .wd_clr  (bus_wdata[12]),
    .wr_ctrl (wr_ctrl),
    .sts_vec (sts_vec),
    .msk_vec (msk_vec),
    .pin_out (pin_out),
    .pin_oe  (pin_oe),
    .irq     (irq)
);

// File: tb/gpio_pin_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_pin_ctrl_bench;
    localparam int NP = 40;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b1;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out;
    logic [NP-1:0] pin_oe;
    logic          irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    gpio_pin_ctrl #(.NUM_PINS(NP), .ADDR_W(AW)) u_gpio_pin_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .irq       (irq)
    );

    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] data;
    } vec_t;

    // R1 decode, R2 field readback, R3 bit13 write ignored, R9 group word write ignored
    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'h60, 32'h0000_03FF},
        '{1'b0, 8'h60, 32'h0000_03FF},
        '{1'b1, 8'h60, 32'hFFFF_F000},
        '{1'b0, 8'h60, 32'h0000_0000},
        '{1'b1, 8'h87, 32'h0000_002A},
        '{1'b0, 8'h87, 32'h0000_002A},
        '{1'b0, 8'h86, 32'h0000_0000},
        '{1'b1, 8'h40, 32'hFFFF_FFFF},
        '{1'b0, 8'h40, 32'h0000_0000},
        '{1'b0, 8'h10, 32'h0000_0000},
        '{1'b1, 8'h10, 32'h0000_FFFF},
        '{1'b0, 8'h88, 32'h0000_0000}
    };

    function automatic logic [7:0] ctl(input int p);
        return 8'(8'h60 + p);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; bus_sel = 1'b1; bus_wr = 1'b0;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic sts_of(input int p, output logic s);
        logic [31:0] w;
        bus_read(ctl(p), w);
        s = w[12];
    endtask

    initial begin
        #(8 * 100000);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd0, 32'd1);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic s;
        #1 rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R5: reset state
        bus_read(ctl(3), rd);
        check("R5 ctrl word after reset", rd, 32'h0);
        check("R5 pin_oe after reset", 32'(pin_oe[31:0]), 32'h0);
        check("R5 irq after reset", 32'(irq), 32'h0);

        // table walk
        for (int v = 0; v < NV; v++) begin
            if (VECS[v].wr) begin
                bus_write(VECS[v].addr, VECS[v].data);
            end else begin
                bus_read(VECS[v].addr, rd);
                check($sformatf("R1 R2 R3 R9 vector %0d", v), rd, VECS[v].data);
            end
        end
        bus_write(ctl(0), 32'h0);
        bus_write(ctl(39), 32'h0);

        // R6 rising edge on pin 2, with R3 synchroniser latency
        bus_write(ctl(2), 32'h0C);
        pin_in[2] = 1'b1;
        tick(2);
        bus_read(ctl(2), rd);
        check("R3 bit13 after two edges", 32'(rd[13]), 32'h1);
        check("R6 no status before third edge", 32'(rd[12]), 32'h0);
        tick(1);
        sts_of(2, s);
        check("R6 rising edge sets status", 32'(s), 32'h1);
        check("R10 irq with enabled status", 32'(irq), 32'h1);
        bus_read(8'h40, rd);
        check("R9 group word mirrors pin 2", rd, 32'h4);
        bus_write(ctl(2), 32'h0C);          // bit12 = 0: no effect
        sts_of(2, s);
        check("R8 write of 0 keeps status", 32'(s), 32'h1);
        bus_write(ctl(2), 32'h100C);
        sts_of(2, s);
        check("R8 write of 1 clears status", 32'(s), 32'h0);
        check("R10 irq low after ack", 32'(irq), 32'h0);

        // R6 falling edge on pin 5
        bus_write(ctl(5), 32'h04);
        pin_in[5] = 1'b1;
        tick(4);
        sts_of(5, s);
        check("R6 falling mode ignores rise", 32'(s), 32'h0);
        pin_in[5] = 1'b0;
        tick(3);
        sts_of(5, s);
        check("R6 falling edge sets status", 32'(s), 32'h1);
        bus_write(ctl(5), 32'h1004);

        // R6 both edges on pin 6
        bus_write(ctl(6), 32'h2C);
        pin_in[6] = 1'b1;
        tick(3);
        sts_of(6, s);
        check("R6 both-edge mode on rise", 32'(s), 32'h1);
        bus_write(ctl(6), 32'h102C);
        pin_in[6] = 1'b0;
        tick(3);
        sts_of(6, s);
        check("R6 both-edge mode on fall", 32'(s), 32'h1);
        bus_write(ctl(6), 32'h102C);

        // R7 level high on pin 7, clear wins over concurrent detection
        bus_write(ctl(7), 32'h1C);
        pin_in[7] = 1'b1;
        tick(3);
        sts_of(7, s);
        check("R6 level high sets status", 32'(s), 32'h1);
        bus_write(ctl(7), 32'h101C);
        sts_of(7, s);
        check("R8 clear wins over active level", 32'(s), 32'h0);
        tick(1);
        sts_of(7, s);
        check("R7 level re-asserts next edge", 32'(s), 32'h1);
        pin_in[7] = 1'b0;
        tick(3);
        bus_write(ctl(7), 32'h101C);
        tick(2);
        sts_of(7, s);
        check("R7 no re-assert once level gone", 32'(s), 32'h0);

        // R6 level low on pin 33, R9 second group word
        bus_write(ctl(33), 32'h14);
        tick(1);
        sts_of(33, s);
        check("R6 level low sets status", 32'(s), 32'h1);
        bus_read(8'h41, rd);
        check("R9 group 1 word mirrors pin 33", rd, 32'h2);
        check("R10 irq from pin 33", 32'(irq), 32'h1);
        pin_in[33] = 1'b1;
        tick(3);
        bus_write(ctl(33), 32'h1014);
        bus_read(8'h41, rd);
        check("R9 group 1 word after ack", rd, 32'h0);

        // R11 mask on pin 4
        bus_write(ctl(4), 32'h20C);
        pin_in[4] = 1'b1;
        tick(4);
        sts_of(4, s);
        check("R11 masked pin records nothing", 32'(s), 32'h0);
        check("R11 irq stays low", 32'(irq), 32'h0);

        // R6 unused trigger code on pin 9
        bus_write(ctl(9), 32'h24);
        pin_in[9] = 1'b1;
        tick(4);
        sts_of(9, s);
        check("R6 code 100 detects nothing", 32'(s), 32'h0);

        // R10 status recorded with enable off on pin 8
        bus_write(ctl(8), 32'h08);
        pin_in[8] = 1'b1;
        tick(3);
        sts_of(8, s);
        check("R10 status with enable off", 32'(s), 32'h1);
        check("R10 irq low with enable off", 32'(irq), 32'h0);
        bus_write(ctl(8), 32'h1008);

        // R4 output path on pin 10
        bus_write(ctl(10), 32'h03);
        check("R4 pin_out follows bit0", 32'(pin_out[10]), 32'h1);
        check("R4 pin_oe follows bit1", 32'(pin_oe[10]), 32'h1);
        bus_write(ctl(10), 32'h02);
        check("R4 pin_out cleared", 32'(pin_out[10]), 32'h0);
        check("R4 pin_oe still set", 32'(pin_oe[10]), 32'h1);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule